// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out the program counter of the next instruction for an 8-bit controller with a 16-bit code space. Each cycle it takes the current PC, the opcode and its two operand bytes, the accumulator, the data pointer, a branch kind, a condition flag and an instruction length. From these it selects one candidate target: a sequential step by the instruction length, a signed short hop taken after the PC has advanced past the instruction, an in-page absolute jump, a full-range long jump, or an accumulator-indexed jump.

In the same cycle it also forms a code-read address for table lookups. The base of that address is either the data pointer or the advanced PC, and the accumulator is added to it as an unsigned offset. Both results are registered and appear one clock after the inputs are presented. The caller handles the stack work for calls and returns, and it also handles instruction fetch.

Top module: `branch_target_gen`

## Requirements
- R1: While rst_ni is low, next_pc_o and fetch_addr_o are 0x0000.
- R2: With br_kind_i = 0 (sequential), next_pc_o one clock later equals pc_i + ilen_i, where ilen_i is the 2-bit instruction length.
- R3: With br_kind_i = 1 (2-byte relative), next_pc_o equals pc_i + 2 + sign-extended byte2_i when cond_i is 1, and pc_i + 2 when cond_i is 0. The offset covers -128 to +127.
- R4: With br_kind_i = 2 (3-byte relative), next_pc_o equals pc_i + 3 + sign-extended byte3_i when cond_i is 1, and pc_i + 3 when cond_i is 0.
- R5: With br_kind_i = 3 (absolute), next_pc_o is built from bits 15:11 of pc_i + 2, then opcode_i bits 7:5, then byte2_i, so the target stays in the 2K page of the advanced PC. cond_i has no effect.
- R6: With br_kind_i = 4 (long), next_pc_o equals {byte2_i, byte3_i}, with byte2_i as the high byte. cond_i has no effect.
- R7: With br_kind_i = 5 (indexed jump), next_pc_o equals dptr_i plus acc_i, with acc_i zero-extended.
- R8: On every cycle, regardless of br_kind_i, fetch_addr_o one clock later equals the base plus zero-extended acc_i. The base is dptr_i when rd_base_i = 0 and pc_i + ilen_i when rd_base_i = 1.
- R9: Every 16-bit sum wraps modulo 65536.
- R10: br_kind_i codes 6 and 7 behave exactly as sequential advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 16 | Address of the current instruction |
| opcode_i | input | 8 | First instruction byte |
| byte2_i | input | 8 | Second instruction byte |
| byte3_i | input | 8 | Third instruction byte |
| acc_i | input | 8 | Accumulator |
| dptr_i | input | 16 | Data pointer |
| br_kind_i | input | 3 | Branch kind code |
| cond_i | input | 1 | Branch condition met |
| ilen_i | input | 2 | Instruction length in bytes |
| rd_base_i | input | 1 | Table-read base: 0 data pointer, 1 advanced PC |
| next_pc_o | output | 16 | Registered next program counter |
| fetch_addr_o | output | 16 | Registered code-read address |

## Verification
The table-read address and the next-PC choice are computed in the same cycle. The PC-based read also depends on the same advanced PC that feeds the sequential and relative paths. The bench provokes this overlap by presenting a taken relative branch together with a PC-based table read, and then the same branch with a data-pointer-based read. It judges the cycle by checking that both registered outputs match their own requirement in the same sample. A fault in the sharing of the advanced PC would show up in one output but not in the other.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    BR_SEQ  = 3'd0,
    BR_REL2 = 3'd1,
    BR_REL3 = 3'd2,
    BR_ABS  = 3'd3,
    BR_LONG = 3'd4,
    BR_IDX  = 3'd5
  } br_kind_e;
endpackage

// File: rtl/bt_pc_step.sv
module bt_pc_step #(
  parameter int AW = 16,
  parameter int SW = 2
) (
  input  logic [AW-1:0] pc_i,
  input  logic [SW-1:0] step_i,
  output logic [AW-1:0] pc_o
);
  assign pc_o = pc_i + AW'(step_i);
endmodule

// File: rtl/bt_off_add.sv
module bt_off_add #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter bit SIGNED = 1'b0
) (
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] off_i,
  output logic [AW-1:0] sum_o
);
  logic [AW-1:0] off_ext;
  generate
    if (SIGNED) begin : g_sext
      assign off_ext = {{(AW-DW){off_i[DW-1]}}, off_i};
    end else begin : g_zext
      assign off_ext = {{(AW-DW){1'b0}}, off_i};
    end
  endgenerate
  assign sum_o = base_i + off_ext;
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
  import bt_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] opcode_i,
  input  logic [DW-1:0] byte2_i,
  input  logic [DW-1:0] byte3_i,
  input  logic [DW-1:0] acc_i,
  input  logic [AW-1:0] dptr_i,
  input  logic [2:0]    br_kind_i,
  input  logic          cond_i,
  input  logic [LW-1:0] ilen_i,
  input  logic          rd_base_i,
  output logic [AW-1:0] next_pc_o,
  output logic [AW-1:0] fetch_addr_o
);
  localparam int PAGE_W = DW + 3;
  localparam logic [AW-1:0] ADV2 = AW'(2);

  logic [AW-1:0] pc_len, abs_tgt, long_tgt, idx_tgt;
  logic [AW-1:0] fetch_base, fetch_tgt, npc_d;

  bt_pc_step #(.AW(AW), .SW(LW)) u_seq (
    .pc_i(pc_i), .step_i(ilen_i), .pc_o(pc_len)
  );

  // Relative paths: index 0 is the 2-byte form, index 1 the 3-byte form
  generate
    for (genvar g = 0; g < 2; g++) begin : g_rel
      logic [AW-1:0] adv, hop, tgt;
      bt_pc_step #(.AW(AW), .SW(LW)) u_adv (
        .pc_i(pc_i), .step_i(LW'(g + 2)), .pc_o(adv)
      );
      bt_off_add #(.AW(AW), .DW(DW), .SIGNED(1'b1)) u_hop (
        .base_i(adv), .off_i((g == 0) ? byte2_i : byte3_i), .sum_o(hop)
      );
      assign tgt = cond_i ? hop : adv;
    end
  endgenerate

  // In-page target keeps the page of the PC after the 2-byte instruction
  assign abs_tgt  = {g_rel[0].adv[AW-1:PAGE_W], opcode_i[DW-1:DW-3], byte2_i};
  assign long_tgt = AW'({byte2_i, byte3_i});

  bt_off_add #(.AW(AW), .DW(DW), .SIGNED(1'b0)) u_idx (
    .base_i(dptr_i), .off_i(acc_i), .sum_o(idx_tgt)
  );

  assign fetch_base = rd_base_i ? pc_len : dptr_i;
  bt_off_add #(.AW(AW), .DW(DW), .SIGNED(1'b0)) u_fetch (
    .base_i(fetch_base), .off_i(acc_i), .sum_o(fetch_tgt)
  );

  always_comb begin
    case (br_kind_e'(br_kind_i))
      BR_REL2: npc_d = g_rel[0].tgt;
      BR_REL3: npc_d = g_rel[1].tgt;
      BR_ABS:  npc_d = abs_tgt;
      BR_LONG: npc_d = long_tgt;
      BR_IDX:  npc_d = idx_tgt;
      default: npc_d = pc_len;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o    <= '0;
      fetch_addr_o <= '0;
    end else begin
      next_pc_o    <= npc_d;
      fetch_addr_o <= fetch_tgt;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (next_pc_o == '0 && fetch_addr_o == '0));

  p_rel_fallthru_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_kind_i == 3'd1 && !cond_i) |=> next_pc_o == $past(pc_i) + ADV2);

  p_abs_same_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_kind_i == 3'd3 |=>
      next_pc_o[AW-1:PAGE_W] == (($past(pc_i) + ADV2) >> PAGE_W));

  p_long_bytes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_kind_i == 3'd4 |=> next_pc_o == AW'({$past(byte2_i), $past(byte3_i)}));

  p_idx_sum_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_kind_i == 3'd5 |=> next_pc_o == $past(dptr_i) + AW'($past(acc_i)));
endmodule

// File: tb/test_branch_target_gen.sv
module test_branch_target_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pc, dptr;
  logic [7:0]  opc, b2, b3, acc;
  logic [2:0]  kind;
  logic        cond, rbase;
  logic [1:0]  ilen;
  logic [15:0] next_pc, fetch_addr;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_gen i_branch_target_gen (
    .clk_i(clk), .rst_ni(rst_ni), .pc_i(pc), .opcode_i(opc), .byte2_i(b2),
    .byte3_i(b3), .acc_i(acc), .dptr_i(dptr), .br_kind_i(kind), .cond_i(cond),
    .ilen_i(ilen), .rd_base_i(rbase), .next_pc_o(next_pc), .fetch_addr_o(fetch_addr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, registered result sampled at following negedge
  task automatic apply(input logic [2:0] k, input logic [15:0] p, input logic [1:0] l,
                       input logic c, input logic [7:0] o, input logic [7:0] x2,
                       input logic [7:0] x3, input logic [7:0] a, input logic [15:0] d,
                       input logic rb);
    @(negedge clk);
    kind = k; pc = p; ilen = l; cond = c; opc = o; b2 = x2; b3 = x3;
    acc = a; dptr = d; rbase = rb;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 next_pc", next_pc, 16'h0000);
    chk("R1 fetch", fetch_addr, 16'h0000);
  endtask

  task automatic t_seq;
    apply(3'd0, 16'h1234, 2'd3, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0);
    chk("R2 step3", next_pc, 16'h1237);
    apply(3'd0, 16'hFFFF, 2'd2, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0);
    chk("R2 R9 wrap", next_pc, 16'h0001);
  endtask

  task automatic t_rel2;
    apply(3'd1, 16'h1000, 2'd2, 1'b1, 8'h00, 8'h10, 8'h00, 8'h00, 16'h0000, 1'b0);
    chk("R3 fwd", next_pc, 16'h1012);
    apply(3'd1, 16'h1000, 2'd2, 1'b1, 8'h00, 8'h80, 8'h00, 8'h00, 16'h0000, 1'b0);
    chk("R3 -128", next_pc, 16'h0F82);
    apply(3'd1, 16'h1000, 2'd2, 1'b0, 8'h00, 8'h80, 8'h00, 8'h00, 16'h0000, 1'b0);
    chk("R3 not taken", next_pc, 16'h1002);
    apply(3'd1, 16'hFFFE, 2'd2, 1'b1, 8'h00, 8'h7F, 8'h00, 8'h00, 16'h0000, 1'b0);
    chk("R3 R9 +127 wrap", next_pc, 16'h007F);
  endtask

  task automatic t_rel3;
    apply(3'd2, 16'h2000, 2'd3, 1'b1, 8'h00, 8'h55, 8'hFE, 8'h00, 16'h0000, 1'b0);
    chk("R4 back", next_pc, 16'h2001);
    apply(3'd2, 16'h2000, 2'd3, 1'b0, 8'h00, 8'h55, 8'hFE, 8'h00, 16'h0000, 1'b0);
    chk("R4 not taken", next_pc, 16'h2003);
  endtask

  task automatic t_abs;
    apply(3'd3, 16'h37FE, 2'd2, 1'b0, 8'hE1, 8'h5A, 8'h00, 8'h00, 16'h0000, 1'b0);
    chk("R5 page after advance", next_pc, 16'h3F5A);
    apply(3'd3, 16'h1000, 2'd2, 1'b1, 8'h21, 8'hFF, 8'h00, 8'h00, 16'h0000, 1'b0);
    chk("R5 page kept", next_pc, 16'h11FF);
  endtask

  task automatic t_long;
    apply(3'd4, 16'h0123, 2'd3, 1'b0, 8'h02, 8'hAB, 8'hCD, 8'h00, 16'h0000, 1'b0);
    chk("R6 hi/lo", next_pc, 16'hABCD);
  endtask

  task automatic t_idx;
    apply(3'd5, 16'h0000, 2'd1, 1'b0, 8'h73, 8'h00, 8'h00, 8'h80, 16'h4000, 1'b0);
    chk("R7 unsigned acc", next_pc, 16'h4080);
    apply(3'd5, 16'h0000, 2'd1, 1'b0, 8'h73, 8'h00, 8'h00, 8'h20, 16'hFFF0, 1'b0);
    chk("R7 R9 wrap", next_pc, 16'h0010);
  endtask

  task automatic t_fetch;
    apply(3'd0, 16'h0700, 2'd1, 1'b0, 8'h93, 8'h00, 8'h00, 8'h34, 16'h1200, 1'b0);
    chk("R8 dptr base", fetch_addr, 16'h1234);
    apply(3'd0, 16'h0100, 2'd1, 1'b0, 8'h83, 8'h00, 8'h00, 8'hFF, 16'h1200, 1'b1);
    chk("R8 pc base", fetch_addr, 16'h0200);
  endtask

  task automatic t_overlap;
    apply(3'd1, 16'h0500, 2'd2, 1'b1, 8'h00, 8'h04, 8'h00, 8'h10, 16'h3000, 1'b1);
    chk("R3 overlap npc", next_pc, 16'h0506);
    chk("R8 overlap fetch pc", fetch_addr, 16'h0512);
    apply(3'd1, 16'h0500, 2'd2, 1'b1, 8'h00, 8'h04, 8'h00, 8'h10, 16'h3000, 1'b0);
    chk("R3 overlap npc2", next_pc, 16'h0506);
    chk("R8 overlap fetch dptr", fetch_addr, 16'h3010);
  endtask

  task automatic t_unused;
    apply(3'd6, 16'h0100, 2'd1, 1'b1, 8'h00, 8'h44, 8'h55, 8'h66, 16'h7777, 1'b0);
    chk("R10 code6", next_pc, 16'h0101);
    apply(3'd7, 16'h0100, 2'd3, 1'b1, 8'h00, 8'h44, 8'h55, 8'h66, 16'h7777, 1'b0);
    chk("R10 code7", next_pc, 16'h0103);
  endtask

  initial begin
    kind = '0; pc = '0; ilen = '0; cond = 1'b0; opc = '0; b2 = '0; b3 = '0;
    acc = '0; dptr = '0; rbase = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_seq();
    t_rel2();
    t_rel3();
    t_abs();
    t_long();
    t_idx();
    t_fetch();
    t_overlap();
    t_unused();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule